// File: doc/BRIEF.md
# Closed-Loop Inner Power Control

This block implements the fast inner loop of reverse-link transmit power control for one link, covering both ends. A power-group strobe arrives once every 1.25 ms. Sixteen groups make one 20 ms frame. On the deciding side, each strobe compares a measured Eb/N0 word against a programmable threshold register. The result is one command bit: 1 asks the far end to lower its power, 0 asks it to raise it.

On the transmitting side, received command bits are captured as they arrive. Only the most recently captured bit is applied, and only on the group strobe. Each application moves a signed correction term by exactly one 1 dB unit, down for a 1 and up for a 0. The correction is added to an open-loop base power to form the transmit power word.

A traffic-start pulse clears the correction and restarts frame counting. A frame-start pulse marks the completion of every sixteenth group.

Top module: `inner_power_loop`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmdBit` is 0, `frameStart` is 0 and `txPower` is 0. The correction term and the group count reset to 0, the stored received bit resets to 0, and the threshold register resets to `THR_RESET` (default 0).
- R2: When `groupStrobe` is high, `cmdBit` is updated in the following cycle. It becomes 1 if the unsigned `measEbNo` is greater than or equal to the threshold, and 0 if it is lower, so equality gives 1. Without a strobe, `cmdBit` holds its value.
- R3: A cycle with `thrLoad` high writes `thrIn` into the threshold register. A decision made in that same cycle still uses the previous threshold.
- R4: A cycle with `rxCmdValid` high stores `rxCmdBit`. A group strobe applies the stored value. When a strobe and a valid bit coincide, the strobe uses the value stored before that cycle.
- R5: On a group strobe, a stored 1 lowers the correction by one unit and a stored 0 raises it by one unit. Without a strobe, the correction does not change.
- R6: The correction saturates: it never rises above `CORR_MAX` (default 31) or falls below `CORR_MIN` (default -32).
- R7: `trafficStart` clears the correction to 0 and restarts the group count. It takes priority over a strobe in the same cycle, and that strobe then neither steps the correction nor counts toward a frame.
- R8: Each cycle, `txPower` takes the value `basePower` plus the correction as they stood one cycle earlier. Both are two's complement, in 1 dB units. The result is clamped to the signed range of `PWR_W` bits, -512 to 511 by default.
- R9: `frameStart` is high for exactly one cycle, in the cycle after every 16th counted strobe since reset or the last `trafficStart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| groupStrobe | input | 1 | One-cycle pulse per power control group |
| trafficStart | input | 1 | Pulse on entry to traffic mode; clears correction and group count |
| measEbNo | input | METRIC_W | Measured received Eb/N0, unsigned |
| thrLoad | input | 1 | Write enable for the threshold register |
| thrIn | input | METRIC_W | New threshold value |
| cmdBit | output | 1 | Command decided at the last strobe (1 = power down) |
| rxCmdValid | input | 1 | Received command bit is valid this cycle |
| rxCmdBit | input | 1 | Received command bit |
| basePower | input | PWR_W | Open-loop base power, signed dB units |
| txPower | output | PWR_W | Transmit power, signed dB units |
| frameStart | output | 1 | One-cycle pulse after each 16th group |

## Verification
The assertions assume that `groupStrobe` and `trafficStart` are single-cycle events driven synchronously to the clock. They also assume that a frame cannot complete twice in consecutive cycles, which follows from the 16-strobe group count.

The deterministic stimulus keeps strobes and traffic pulses as single-cycle pulses, and separates bursts of strobes by idle gaps. The random phase draws each pulse independently per cycle, so any arrangement of pulses is legal. Each case is compared against a behavioural model in the bench: equal-to-threshold decisions, strobes that coincide with a received bit or with a threshold write, both saturation limits, and power clamping at both ends.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

  // Strobes handed from control to datapath each cycle.
  typedef struct packed {
    logic decide;     // take a new command decision
    logic applyStep;  // move the correction by one unit
    logic stepDown;   // direction of that step (1 = lower)
    logic clearCorr;  // traffic entry: zero the correction
    logic frameTick;  // last group of a frame was counted
  } ipcStrobes_t;

endpackage

// File: rtl/ipc_control.sv
module ipc_control
  import ipc_pkg::*;
#(
  parameter int GROUPS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        groupStrobe,
  input  logic        trafficStart,
  input  logic        rxCmdValid,
  input  logic        rxCmdBit,
  output ipcStrobes_t strobes
);

  localparam int CNT_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam logic [CNT_W-1:0] LAST_GROUP = CNT_W'(GROUPS - 1);

  logic             cmdStore;
  logic [CNT_W-1:0] groupCnt;
  logic             counted;

  assign counted = groupStrobe && !trafficStart;

  // Received bit is held until the next one arrives.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdStore <= 1'b0;
    end else if (rxCmdValid) begin
      cmdStore <= rxCmdBit;
    end
  end

  // Group position within the frame.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      groupCnt <= '0;
    end else if (trafficStart) begin
      groupCnt <= '0;
    end else if (groupStrobe) begin
      if (groupCnt == LAST_GROUP) begin
        groupCnt <= '0;
      end else begin
        groupCnt <= groupCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.decide    = groupStrobe;
    strobes.applyStep = counted;
    strobes.stepDown  = cmdStore;
    strobes.clearCorr = trafficStart;
    strobes.frameTick = counted && (groupCnt == LAST_GROUP);
  end

endmodule

// File: rtl/ipc_datapath.sv
module ipc_datapath
  import ipc_pkg::*;
#(
  parameter int METRIC_W = 12,
  parameter int PWR_W    = 10,
  parameter int CORR_W   = 8,
  parameter int CORR_MIN = -32,
  parameter int CORR_MAX = 31,
  parameter logic [METRIC_W-1:0] THR_RESET = '0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ipcStrobes_t                strobes,
  input  logic [METRIC_W-1:0]        measEbNo,
  input  logic                       thrLoad,
  input  logic [METRIC_W-1:0]        thrIn,
  input  logic signed [PWR_W-1:0]    basePower,
  output logic                       cmdBit,
  output logic                       frameStart,
  output logic signed [PWR_W-1:0]    txPower,
  output logic [METRIC_W-1:0]        thrNow,
  output logic signed [CORR_W-1:0]   corrNow
);

  localparam logic signed [CORR_W:0] STEP_UP = (CORR_W+1)'(1);
  localparam logic signed [CORR_W:0] STEP_DN = -(CORR_W+1)'(1);
  localparam logic signed [CORR_W:0] LIM_HI  = (CORR_W+1)'(CORR_MAX);
  localparam logic signed [CORR_W:0] LIM_LO  = (CORR_W+1)'(CORR_MIN);
  localparam logic signed [PWR_W:0]  PWR_HI  = (PWR_W+1)'((2**(PWR_W-1)) - 1);
  localparam logic signed [PWR_W:0]  PWR_LO  = -(PWR_W+1)'(2**(PWR_W-1));

  logic [METRIC_W-1:0]      thrReg;
  logic signed [CORR_W-1:0] corrQ;
  logic signed [CORR_W:0]   corrSum;
  logic signed [CORR_W:0]   corrSat;
  logic signed [PWR_W:0]    powSum;
  logic signed [PWR_W-1:0]  powSat;
  logic                     decision;

  // Threshold register.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrReg <= THR_RESET;
    end else if (thrLoad) begin
      thrReg <= thrIn;
    end
  end

  // Deciding side: equality counts as "high enough".
  assign decision = (measEbNo >= thrReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdBit <= 1'b0;
    end else if (strobes.decide) begin
      cmdBit <= decision;
    end
  end

  // Correction accumulator with saturation.
  always_comb begin
    corrSum = (CORR_W+1)'(corrQ) + (strobes.stepDown ? STEP_DN : STEP_UP);
    if (corrSum > LIM_HI) begin
      corrSat = LIM_HI;
    end else if (corrSum < LIM_LO) begin
      corrSat = LIM_LO;
    end else begin
      corrSat = corrSum;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      corrQ <= '0;
    end else if (strobes.clearCorr) begin
      corrQ <= '0;
    end else if (strobes.applyStep) begin
      corrQ <= corrSat[CORR_W-1:0];
    end
  end

  // Transmit power: base plus correction, clamped.
  always_comb begin
    powSum = (PWR_W+1)'(basePower) + (PWR_W+1)'(corrQ);
    if (powSum > PWR_HI) begin
      powSat = PWR_HI[PWR_W-1:0];
    end else if (powSum < PWR_LO) begin
      powSat = PWR_LO[PWR_W-1:0];
    end else begin
      powSat = powSum[PWR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPower    <= '0;
      frameStart <= 1'b0;
    end else begin
      txPower    <= powSat;
      frameStart <= strobes.frameTick;
    end
  end

  assign thrNow  = thrReg;
  assign corrNow = corrQ;

endmodule

// File: rtl/inner_power_loop.sv
module inner_power_loop
  import ipc_pkg::*;
#(
  parameter int METRIC_W = 12,
  parameter int PWR_W    = 10,
  parameter int CORR_W   = 8,
  parameter int CORR_MIN = -32,
  parameter int CORR_MAX = 31,
  parameter int GROUPS   = 16,
  parameter logic [METRIC_W-1:0] THR_RESET = '0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    groupStrobe,
  input  logic                    trafficStart,
  input  logic [METRIC_W-1:0]     measEbNo,
  input  logic                    thrLoad,
  input  logic [METRIC_W-1:0]     thrIn,
  output logic                    cmdBit,
  input  logic                    rxCmdValid,
  input  logic                    rxCmdBit,
  input  logic signed [PWR_W-1:0] basePower,
  output logic signed [PWR_W-1:0] txPower,
  output logic                    frameStart
);

  ipcStrobes_t              strobes;
  logic [METRIC_W-1:0]      thrNow;
  logic signed [CORR_W-1:0] corrNow;

  ipc_control #(
    .GROUPS(GROUPS)
  ) uControl (
    .clk          (clk),
    .rstN         (rstN),
    .groupStrobe  (groupStrobe),
    .trafficStart (trafficStart),
    .rxCmdValid   (rxCmdValid),
    .rxCmdBit     (rxCmdBit),
    .strobes      (strobes)
  );

  ipc_datapath #(
    .METRIC_W  (METRIC_W),
    .PWR_W     (PWR_W),
    .CORR_W    (CORR_W),
    .CORR_MIN  (CORR_MIN),
    .CORR_MAX  (CORR_MAX),
    .THR_RESET (THR_RESET)
  ) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .measEbNo   (measEbNo),
    .thrLoad    (thrLoad),
    .thrIn      (thrIn),
    .basePower  (basePower),
    .cmdBit     (cmdBit),
    .frameStart (frameStart),
    .txPower    (txPower),
    .thrNow     (thrNow),
    .corrNow    (corrNow)
  );

endmodule

// File: rtl/ipc_checker.sv
module ipc_checker #(
  parameter int METRIC_W = 12,
  parameter int CORR_W   = 8,
  parameter int CORR_MIN = -32,
  parameter int CORR_MAX = 31
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     groupStrobe,
  input logic                     trafficStart,
  input logic [METRIC_W-1:0]      measEbNo,
  input logic                     cmdBit,
  input logic                     frameStart,
  input logic [METRIC_W-1:0]      thrNow,
  input logic signed [CORR_W-1:0] corrNow
);

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(groupStrobe) |-> cmdBit == $past(cmdBit)); // R2

  AST_CMD_DECIDE: assert property (@(posedge clk) disable iff (!rstN)
    $past(groupStrobe) |-> cmdBit == ($past(measEbNo) >= $past(thrNow))); // R2

  AST_CORR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(groupStrobe) && !$past(trafficStart)) |-> $stable(corrNow)); // R5

  AST_CORR_UNIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(groupStrobe) && !$past(trafficStart)) |->
      ((int'(corrNow) - int'($past(corrNow)) <= 1) &&
       (int'($past(corrNow)) - int'(corrNow) <= 1))); // R5

  AST_CORR_BOUNDS: assert property (@(posedge clk) disable iff (!rstN)
    (int'(corrNow) >= CORR_MIN) && (int'(corrNow) <= CORR_MAX)); // R6

  AST_CORR_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    $past(trafficStart) |-> corrNow == '0); // R7

  AST_FRAME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart); // R9

  AST_FRAME_FROM_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> ($past(groupStrobe) && !$past(trafficStart))); // R9

endmodule

bind inner_power_loop ipc_checker #(
  .METRIC_W (METRIC_W),
  .CORR_W   (CORR_W),
  .CORR_MIN (CORR_MIN),
  .CORR_MAX (CORR_MAX)
) uChecker (
  .clk          (clk),
  .rstN         (rstN),
  .groupStrobe  (groupStrobe),
  .trafficStart (trafficStart),
  .measEbNo     (measEbNo),
  .cmdBit       (cmdBit),
  .frameStart   (frameStart),
  .thrNow       (thrNow),
  .corrNow      (corrNow)
);

// File: tb/inner_power_loop_test.sv
module inner_power_loop_test;

  localparam int METRIC_W = 12;
  localparam int PWR_W    = 10;
  localparam int CMIN     = -32;
  localparam int CMAX     = 31;
  localparam int PMIN     = -512;
  localparam int PMAX     = 511;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    groupStrobe = 1'b0;
  logic                    trafficStart = 1'b0;
  logic [METRIC_W-1:0]     measEbNo = '0;
  logic                    thrLoad = 1'b0;
  logic [METRIC_W-1:0]     thrIn = '0;
  logic                    cmdBit;
  logic                    rxCmdValid = 1'b0;
  logic                    rxCmdBit = 1'b0;
  logic signed [PWR_W-1:0] basePower = '0;
  logic signed [PWR_W-1:0] txPower;
  logic                    frameStart;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // Behavioural model state
  int mThr = 0, mCmd = 0, mStore = 0, mCorr = 0, mCnt = 0, mFrame = 0, mPow = 0;
  int seed = 12345;

  always #10 clk = ~clk;

  inner_power_loop uut (
    .clk(clk), .rstN(rstN), .groupStrobe(groupStrobe), .trafficStart(trafficStart),
    .measEbNo(measEbNo), .thrLoad(thrLoad), .thrIn(thrIn), .cmdBit(cmdBit),
    .rxCmdValid(rxCmdValid), .rxCmdBit(rxCmdBit), .basePower(basePower),
    .txPower(txPower), .frameStart(frameStart)
  );

  function automatic int clampi(int v, int lo, int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    check(tag, "cmdBit", int'(cmdBit), mCmd);
    check(tag, "frameStart", int'(frameStart), mFrame);
    check(tag, "txPower", int'(txPower), mPow);
  endtask

  // One clock: model next state from current inputs, then compare.
  task automatic step(string tag);
    int nThr, nCmd, nStore, nCorr, nCnt, nFrame, nPow;
    nPow   = clampi(int'(basePower) + mCorr, PMIN, PMAX);
    nThr   = thrLoad ? int'(thrIn) : mThr;
    nCmd   = groupStrobe ? ((int'(measEbNo) >= mThr) ? 1 : 0) : mCmd;
    nStore = rxCmdValid ? int'(rxCmdBit) : mStore;
    nCorr  = mCorr;
    nCnt   = mCnt;
    nFrame = 0;
    if (trafficStart) begin
      nCorr = 0;
      nCnt  = 0;
    end else if (groupStrobe) begin
      nCorr  = clampi(mCorr + ((mStore != 0) ? -1 : 1), CMIN, CMAX);
      nFrame = (mCnt == 15) ? 1 : 0;
      nCnt   = (mCnt + 1) % 16;
    end
    @(posedge clk);
    mThr = nThr; mCmd = nCmd; mStore = nStore; mCorr = nCorr;
    mCnt = nCnt; mFrame = nFrame; mPow = nPow;
    @(negedge clk);
    compareAll(tag);
    groupStrobe = 1'b0;
    trafficStart = 1'b0;
    thrLoad = 1'b0;
    rxCmdValid = 1'b0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic strobes(int n, int gap, string tag);
    for (int i = 0; i < n; i++) begin
      groupStrobe = 1'b1;
      step(tag);
      idle(gap, tag);
    end
  endtask

  function automatic int nextRand();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 32'h7fff;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    compareAll("R1");
    rstN = 1'b1;
    step("R1");

    // R8: base power passes through with zero correction
    basePower = 10'sd100;
    idle(2, "R8");

    // R3: threshold write; same-cycle decision uses old threshold (0)
    thrIn = 12'd100; thrLoad = 1'b1; measEbNo = 12'd50; groupStrobe = 1'b1;
    step("R3");
    measEbNo = 12'd50; groupStrobe = 1'b1;
    step("R3");

    // R2: equal gives 1, below gives 0, above gives 1; hold between strobes
    measEbNo = 12'd100; groupStrobe = 1'b1; step("R2");
    measEbNo = 12'd99;  idle(2, "R2");
    groupStrobe = 1'b1; step("R2");
    measEbNo = 12'd101; idle(2, "R2");
    groupStrobe = 1'b1; step("R2");

    // R7: clean start of correction and frame count
    trafficStart = 1'b1; step("R7");

    // R4 / R5: stored bit applied only on strobe
    rxCmdValid = 1'b1; rxCmdBit = 1'b1; step("R4");
    idle(2, "R5");
    groupStrobe = 1'b1; step("R5");
    rxCmdValid = 1'b1; rxCmdBit = 1'b0; groupStrobe = 1'b1; step("R4");
    idle(1, "R4");
    groupStrobe = 1'b1; step("R4");
    idle(3, "R5");

    // R6 / R8: saturate upward, clamp power high
    basePower = 10'sd500;
    strobes(70, 1, "R6");
    idle(2, "R8");
    // saturate downward, clamp power low
    rxCmdValid = 1'b1; rxCmdBit = 1'b1; step("R6");
    basePower = -10'sd500;
    strobes(80, 1, "R6");
    idle(2, "R8");

    // R7: traffic start wins over a simultaneous strobe
    trafficStart = 1'b1; groupStrobe = 1'b1; step("R7");
    idle(2, "R7");

    // R9: frame pulse every 16th counted strobe
    basePower = 10'sd0;
    strobes(40, 2, "R9");
    strobes(20, 0, "R9");

    // Mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      groupStrobe  = (nextRand() % 4) == 0;
      trafficStart = (nextRand() % 200) == 0;
      rxCmdValid   = (nextRand() % 3) == 0;
      rxCmdBit     = nextRand() % 2;
      thrLoad      = (nextRand() % 50) == 0;
      thrIn        = METRIC_W'(nextRand());
      measEbNo     = METRIC_W'(nextRand());
      basePower    = PWR_W'(nextRand() % 1024);
      step("R8");
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule